// File: doc/BRIEF.md
# Serial ADC Sampling Master

This block drives a 12-bit successive-approximation converter that has a three-wire serial port: a serial clock, an active-low chip select and one data line from the converter. A programmable divider makes the serial clock from the master clock. A sample timer counts whole serial-clock periods, so the chip-select falling edges are evenly spaced in time and the sampling stays equidistant whatever divider is chosen.

Each sample point opens a 16-clock frame. The block shifts the converter's data in on the falling serial-clock edges, most significant bit first, and presents the low 12 bits of the received word with a one-cycle valid strobe. A power-down request makes the next frame only 8 clocks long. That truncated frame sends the converter to sleep and yields no result. The following normal frame wakes the converter again.

Top module: `adc_sample_master`

## Requirements
- R1: While reset is asserted, sclk_o is 1, cs_n_o is 1, valid_o is 0 and result_o is 0.
- R2: sclk_o stays high for div_i+1 master clocks and then low for div_i+1 master clocks, so one serial period is 2*(div_i+1) master clocks.
- R3: cs_n_o changes level only in a master-clock cycle in which sclk_o goes from 0 to 1.
- R4: In a normal frame, cs_n_o stays low across exactly 16 falling edges of sclk_o.
- R5: Consecutive falling edges of cs_n_o are exactly P*2*(div_i+1) master clocks apart, where P = period_i when period_i >= 18.
- R6: sdata_i is sampled on each falling edge of sclk_o while cs_n_o is low. The first bit sampled is bit 15 of the received word. result_o takes bits 11:0 of the word, which are the last 12 bits received.
- R7: valid_o is high for exactly one master clock: the first cycle in which cs_n_o is high again after a 16-clock frame. result_o changes only in that cycle.
- R8: A one-cycle pulse on pd_req_i is held until the next frame starts. That frame has exactly 8 sclk_o falling edges, raises no valid_o and leaves result_o unchanged. The frame after it has 16 edges again.
- R9: A period_i value below 18, including 0, behaves as 18 (P = 18 in R5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_i | input | 8 | Serial clock divider; half period is div_i+1 master clocks |
| period_i | input | 16 | Sample interval in serial-clock periods (minimum 18) |
| pd_req_i | input | 1 | Power-down request; shortens the next frame to 8 clocks |
| sdata_i | input | 1 | Serial data from the converter |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| cs_n_o | output | 1 | Active-low chip select, one low pulse per frame |
| result_o | output | 12 | Last converted sample |
| valid_o | output | 1 | One-cycle strobe marking a new result_o |

## Verification
The bench runs directed divider and period pairs, then random ones: divider 0 (fastest clock), a mid divider and the largest divider. These separate an off-by-one in the half-period from one in the frame interval. Periods of 0, 5, 17, exactly 18 and above 18 show whether the clamp to 18 is applied and whether the interval counts whole serial periods. Random 16-bit words, driven one bit per falling edge, show bit order and which 12 bits are kept. A power-down pulse sent in the middle of a frame must shorten only the next frame, and that frame must produce no valid strobe and no change of result.

// File: rtl/adc_master_pkg.sv
package adc_master_pkg;
  localparam int unsigned WORD_LEN   = 16;
  localparam int unsigned SHORT_LEN  = 8;
  localparam int unsigned RES_W      = 12;
  localparam int unsigned MIN_GAP    = 2;
  localparam int unsigned MIN_PERIOD = WORD_LEN + MIN_GAP;

  typedef enum logic {
    FRM_FULL  = 1'b0,
    FRM_SHORT = 1'b1
  } frame_kind_e;
endpackage

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             sclk_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             toggle;

  always_comb begin
    toggle = (cnt_q >= div_i);
    cnt_d  = toggle ? '0 : cnt_q + 1'b1;
    sclk_d = toggle ? ~sclk_q : sclk_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk_o = sclk_q;
  assign rise_o = toggle & ~sclk_q;
  assign fall_o = toggle & sclk_q;
endmodule

// File: rtl/frame_timer.sv
module frame_timer
  import adc_master_pkg::*;
#(
  parameter int unsigned PER_W    = 16,
  parameter int unsigned FULL_LEN = WORD_LEN,
  parameter int unsigned PD_LEN   = SHORT_LEN,
  parameter int unsigned MIN_PER  = MIN_PERIOD
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PER_W-1:0] period_i,
  input  logic             pd_req_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             cs_n_o,
  output logic             sample_o,
  output logic             full_done_o
);
  localparam logic [PER_W-1:0] MinPer  = PER_W'(MIN_PER);
  localparam logic [PER_W-1:0] FullLen = PER_W'(FULL_LEN);
  localparam logic [PER_W-1:0] PdLen   = PER_W'(PD_LEN);

  logic [PER_W-1:0] ptim_q, ptim_d;
  logic [PER_W-1:0] eff_per, cur_len;
  logic             cs_n_q, cs_n_d;
  frame_kind_e      kind_q, kind_d;
  logic             pend_q, pend_d;
  logic             start, stop;

  always_comb begin
    eff_per = (period_i < MinPer) ? MinPer : period_i;
    cur_len = (kind_q == FRM_SHORT) ? PdLen : FullLen;
    start   = rise_i & cs_n_q & (ptim_q >= eff_per - 1'b1);
    stop    = rise_i & ~cs_n_q & (ptim_q == cur_len - 1'b1);

    ptim_d = ptim_q;
    if (start)                        ptim_d = '0;
    else if (rise_i && ptim_q != '1)  ptim_d = ptim_q + 1'b1;

    cs_n_d = cs_n_q;
    if (start)     cs_n_d = 1'b0;
    else if (stop) cs_n_d = 1'b1;

    kind_d = kind_q;
    if (start) kind_d = pend_q ? FRM_SHORT : FRM_FULL;

    pend_d = (pend_q & ~start) | pd_req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptim_q <= '0;
      cs_n_q <= 1'b1;
      kind_q <= FRM_FULL;
      pend_q <= 1'b0;
    end else begin
      ptim_q <= ptim_d;
      cs_n_q <= cs_n_d;
      kind_q <= kind_d;
      pend_q <= pend_d;
    end
  end

  assign cs_n_o      = cs_n_q;
  assign sample_o    = fall_i & ~cs_n_q;
  assign full_done_o = stop & (kind_q == FRM_FULL);

  AST_FRAME_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_q |-> (ptim_q < cur_len)); // R4

  AST_NO_START_IN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_q) |-> ($past(ptim_q) >= MinPer - 1'b1)); // R9
endmodule

// File: rtl/rx_capture.sv
module rx_capture #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned RES_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_i,
  input  logic             sdata_i,
  input  logic             done_i,
  output logic [RES_W-1:0] result_o,
  output logic             valid_o
);
  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [RES_W-1:0]  res_q, res_d;
  logic              vld_q, vld_d;

  always_comb begin
    shreg_d = sample_i ? {shreg_q[WORD_W-2:0], sdata_i} : shreg_q;
    res_d   = done_i ? shreg_q[RES_W-1:0] : res_q;
    vld_d   = done_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      res_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      res_q   <= res_d;
      vld_q   <= vld_d;
    end
  end

  assign result_o = res_q;
  assign valid_o  = vld_q;

  AST_NO_SHIFT_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !sample_i); // R6
endmodule

// File: rtl/adc_sample_master.sv
module adc_sample_master
  import adc_master_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned PER_W = 16,
  parameter int unsigned OUT_W = RES_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  input  logic [PER_W-1:0] period_i,
  input  logic             pd_req_i,
  input  logic             sdata_i,
  output logic             sclk_o,
  output logic             cs_n_o,
  output logic [OUT_W-1:0] result_o,
  output logic             valid_o
);
  logic rst_meta_q, rst_sync_q;
  logic rise, fall, sample, full_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_q),
    .div_i  (div_i),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  frame_timer #(
    .PER_W    (PER_W),
    .FULL_LEN (WORD_LEN),
    .PD_LEN   (SHORT_LEN),
    .MIN_PER  (MIN_PERIOD)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_q),
    .period_i    (period_i),
    .pd_req_i    (pd_req_i),
    .rise_i      (rise),
    .fall_i      (fall),
    .cs_n_o      (cs_n_o),
    .sample_o    (sample),
    .full_done_o (full_done)
  );

  rx_capture #(.WORD_W(WORD_LEN), .RES_W(OUT_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_q),
    .sample_i (sample),
    .sdata_i  (sdata_i),
    .done_i   (full_done),
    .result_o (result_o),
    .valid_o  (valid_o)
  );

  AST_CS_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    !$stable(cs_n_o) |-> $rose(sclk_o)); // R3

  AST_VALID_AT_CS_END: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    valid_o |-> $rose(cs_n_o)); // R7

  AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    valid_o |=> !valid_o); // R7

  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    !valid_o |-> $stable(result_o)); // R8
endmodule

// File: tb/adc_sample_master_tb.sv
module adc_sample_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  div_r = 8'd3;
  logic [15:0] per_r = 16'd20;
  logic        pd_r = 1'b0;
  logic        sdata_r = 1'b0;
  logic        sclk, cs_n, valid;
  logic [11:0] result;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  adc_sample_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .div_i(div_r), .period_i(per_r),
    .pd_req_i(pd_r), .sdata_i(sdata_r), .sclk_o(sclk), .cs_n_o(cs_n),
    .result_o(result), .valid_o(valid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_interval(input int d, input int p);
    int eff;
    eff = (p < 18) ? 18 : p;
    return eff * 2 * (d + 1);
  endfunction

  // monitor state
  logic        p_sclk, p_cs;
  int          run_len, run_ok;
  int          gap_cyc, gap_ok;
  int          falls, exp_len, idx;
  int          frames;
  bit          short_pend;
  logic [15:0] word;
  logic [11:0] last_res;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_sclk <= 1'b1; p_cs <= 1'b1;
      run_len <= 0; run_ok <= 0; gap_cyc <= 0; gap_ok <= 0;
      falls <= 0; exp_len <= 16; idx <= -1; frames <= 0;
      last_res <= 12'd0; sdata_r <= 1'b0;
    end else begin
      // R2 half-period
      if (sclk != p_sclk) begin
        if (run_ok != 0) chk(run_len == div_r + 1, "R2", "sclk half period", run_len, div_r + 1);
        run_len <= 1; run_ok <= 1;
      end else run_len <= run_len + 1;

      // R3 chip select moves only with sclk rising
      if (cs_n != p_cs)
        chk(p_sclk == 1'b0 && sclk == 1'b1, "R3", "cs edge not on sclk rise", int'(sclk), 1);

      if (p_cs && !cs_n) begin
        if (gap_ok != 0) chk(gap_cyc == exp_interval(div_r, per_r), (per_r < 18) ? "R9" : "R5",
                             "cs interval", gap_cyc, exp_interval(div_r, per_r));
        gap_cyc <= 1; gap_ok <= 1;
        exp_len <= short_pend ? 8 : 16;
        short_pend = 1'b0;
        falls <= 0;
        word = 16'($urandom);
        idx <= 15;
        sdata_r <= word[15];
        frames <= frames + 1;
      end else begin
        gap_cyc <= gap_cyc + 1;
        if (!cs_n && p_sclk && !sclk) begin
          falls <= falls + 1;
          idx <= idx - 1;
          sdata_r <= (idx >= 1) ? word[idx-1] : 1'b0;
        end
      end

      if (!p_cs && cs_n) begin
        chk(falls == exp_len, (exp_len == 8) ? "R8" : "R4", "falling edges in frame", falls, exp_len);
        if (exp_len == 16) begin
          chk(valid == 1'b1, "R7", "valid at frame end", int'(valid), 1);
          chk(result == word[11:0], "R6", "result value", int'(result), int'(word[11:0]));
          last_res <= result;
        end else begin
          chk(valid == 1'b0, "R8", "valid after power-down frame", int'(valid), 0);
          chk(result == last_res, "R8", "result kept", int'(result), int'(last_res));
        end
      end else if (valid)
        chk(1'b0, "R7", "valid outside frame end", 1, 0);

      p_sclk <= sclk; p_cs <= cs_n;
    end
  end

  task automatic run_cfg(input int d, input int p, input int n, input bit do_pd);
    rst_n = 1'b0;
    div_r = 8'(d); per_r = 16'(p); pd_r = 1'b0;
    short_pend = 1'b0;
    repeat (3) @(negedge clk);
    chk(sclk == 1'b1, "R1", "sclk in reset", int'(sclk), 1);
    chk(cs_n == 1'b1, "R1", "cs_n in reset", int'(cs_n), 1);
    chk(valid == 1'b0, "R1", "valid in reset", int'(valid), 0);
    chk(result == 12'd0, "R1", "result in reset", int'(result), 0);
    rst_n = 1'b1;
    while (frames < 2) @(negedge clk);
    if (do_pd) begin
      repeat (3) @(negedge clk);
      pd_r = 1'b1;
      short_pend = 1'b1;
      @(negedge clk);
      pd_r = 1'b0;
    end
    while (frames < n) @(negedge clk);
    while (!cs_n) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd7));
    run_cfg(3, 20, 5, 1'b1);
    run_cfg(0, 18, 5, 1'b1);
    run_cfg(0, 0, 4, 1'b0);
    run_cfg(1, 5, 4, 1'b0);
    run_cfg(2, 17, 4, 1'b1);
    run_cfg(255, 18, 3, 1'b0);
    run_cfg(0, 33, 4, 1'b0);
    for (int k = 0; k < 6; k++)
      run_cfg(int'($urandom % 4), int'($urandom % 40), 5, k[0]);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule